// File: doc/BRIEF.md
# Early/Late Digital Phase Detector

This block finds out how far a local 1 Hz clock sits from a once-per-second reference pulse. Its timing point on the local clock is the falling edge, and on the pulse the leading edge. If the pulse arrives while the local clock is high, the clock is late. If the pulse arrives while the local clock is low, the clock is early. The time gap is measured by counting system clock ticks in one of two separate counters, one for each direction. The counted gap becomes a signed proportional word and a scaled integral-input word, which a downstream loop filter can use.

The local clock, its double-rate companion and the reference pulse all pass through identical two-flop synchronizers. Their edges are then detected in the system clock domain, so none of them is used as a clock. Each direction has a pending latch that the pulse sets. On the next falling edge of the double-rate clock, the latch moves into an enable flag and clears itself. That falling edge coincides with the next local-clock transition. The enable then lasts until the following falling edge of the double-rate clock, so the correction is shown only for the local-clock half-cycle after the measurement ends.

Top module: `el_phase_det`

## Requirements
- R1: While reset is asserted and after it is released, with no pulse seen, valid_o and late_o are 0, and p_o and i_o are 0.
- R2: A pulse leading edge that is sampled while the local clock is high gives late_o = 1 and a non-negative p_o.
- R3: For a late pulse, p_o equals the number of system cycles from the sampled pulse rise to the sampled local-clock fall. It is shown while the local clock is low after that fall.
- R4: A pulse leading edge that is sampled while the local clock is low gives late_o = 0, with p_o equal to minus the number of system cycles from the sampled local-clock fall to the sampled pulse rise. It is shown during the following high phase.
- R5: In a half-cycle with no pulse edge, no correction follows: valid_o stays 0. This holds even after the early counter has run through a whole low phase.
- R6: valid_o rises two system cycles after the local-clock transition that ends a measurement is sampled. It stays high, with p_o stable, until the next falling edge of the double-rate clock is processed, which is exactly one local half-cycle. The double-rate clock falls at each local-clock transition.
- R7: The counted magnitude saturates at HALF_TICKS, so |p_o| never exceeds HALF_TICKS.
- R8: i_o carries the sign of p_o, and its magnitude is |p_o| shifted right by I_SHIFT.
- R9: Whenever valid_o is 0, p_o, i_o and late_o are all 0.
- R10: Only the first pulse edge within a half-phase counts. Later edges in the same half-phase leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lclk_i | input | 1 | Local 1 Hz clock being disciplined |
| lclk2x_i | input | 1 | Double-rate clock; its falling edges coincide with lclk_i transitions |
| pulse_i | input | 1 | Reference pulse, asynchronous |
| p_o | output | cnt_w(HALF_TICKS)+1 | Signed proportional correction |
| i_o | output | cnt_w(HALF_TICKS)+1 | Signed integral-input correction |
| valid_o | output | 1 | Correction words are meaningful |
| late_o | output | 1 | 1 = late result, 0 = early result |

## Verification
The detector is driven with pulses placed at several offsets on both sides of the local-clock falling edge. These include offsets close to either end of a half-phase, which tell the late path apart from the early path and confirm that the sign follows the half-phase in which the pulse lands. Stretched high and low phases push each counter past HALF_TICKS and show where it clips. A shortened low phase shows that the output window follows the next double-rate edge rather than a fixed length. Periods with two pulses, and periods with none, separate first-edge capture from later edges and show that the free-running early counter never leaks into the output.

// File: rtl/el_pd_pkg.sv
package el_pd_pkg;

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } edge_ev_t;

  function automatic int cnt_w(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/el_pd_edge_sync.sv
module el_pd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 async_i,
  output el_pd_pkg::edge_ev_t  ev_o
);

  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its one-cycle delay
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign ev_o.lvl  = pipe_q[STAGES-1];
  assign ev_o.rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign ev_o.fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/el_pd_interval.sv
module el_pd_interval #(
  parameter bit IS_LATE    = 1'b1,
  parameter int HALF_TICKS = 1000,
  parameter int CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             clr_i,
  input  logic             pulse_rise_i,
  input  logic             xfer_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_TICKS);

  logic arm, run, latch_q;

  generate
    if (IS_LATE) begin : g_late
      // counts from pulse to clock fall
      assign arm = lvl_i;
      assign run = latch_q;
    end else begin : g_early
      // counts from clock fall until pulse latches
      assign arm = ~lvl_i;
      assign run = ~lvl_i & ~latch_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  latch_q <= 1'b0;
    else if (pulse_rise_i && arm) latch_q <= 1'b1;
    else if (xfer_i)              latch_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= 1'b0;
    else if (xfer_i) en_o <= latch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_o <= '0;
    else if (clr_i)                    cnt_o <= '0;
    else if (run && cnt_o != CNT_MAX)  cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/el_phase_det.sv
module el_phase_det #(
  parameter int HALF_TICKS  = 1000,
  parameter int I_SHIFT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                          clk_i,
  input  logic                                          rst_ni,
  input  logic                                          lclk_i,
  input  logic                                          lclk2x_i,
  input  logic                                          pulse_i,
  output logic signed [el_pd_pkg::cnt_w(HALF_TICKS):0]  p_o,
  output logic signed [el_pd_pkg::cnt_w(HALF_TICKS):0]  i_o,
  output logic                                          valid_o,
  output logic                                          late_o
);

  localparam int CNT_W = el_pd_pkg::cnt_w(HALF_TICKS);
  localparam int P_W   = CNT_W + 1;
  localparam int N_IN  = 3;
  localparam int LCLK  = 0;
  localparam int XCLK  = 1;
  localparam int PULS  = 2;

  logic [N_IN-1:0]     raw;
  el_pd_pkg::edge_ev_t ev [N_IN];

  assign raw = {pulse_i, lclk2x_i, lclk_i};

  // equal latency on every input keeps edge order intact
  generate
    for (genvar g = 0; g < N_IN; g++) begin : g_sync
      el_pd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw[g]),
        .ev_o    (ev[g])
      );
    end
  endgenerate

  logic             unused_ev;
  assign unused_ev = ^{ev[XCLK].lvl, ev[XCLK].rise, ev[PULS].lvl, ev[PULS].fall};

  logic [1:0]       en;
  logic [CNT_W-1:0] cnt [2];

  // path 0: late, path 1: early
  generate
    for (genvar g = 0; g < 2; g++) begin : g_path
      el_pd_interval #(
        .IS_LATE    (g == 0),
        .HALF_TICKS (HALF_TICKS),
        .CNT_W      (CNT_W)
      ) u_path (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .lvl_i        (ev[LCLK].lvl),
        .clr_i        ((g == 0) ? ev[LCLK].rise : ev[LCLK].fall),
        .pulse_rise_i (ev[PULS].rise),
        .xfer_i       (ev[XCLK].fall),
        .en_o         (en[g]),
        .cnt_o        (cnt[g])
      );
    end
  endgenerate

  logic [CNT_W-1:0] mag, mag_sh;
  logic [P_W-1:0]   p_pos, i_pos;

  always_comb begin
    if (en[0])      mag = cnt[0];
    else if (en[1]) mag = cnt[1];
    else            mag = '0;
    mag_sh = mag >> I_SHIFT;
    p_pos  = {1'b0, mag};
    i_pos  = {1'b0, mag_sh};
    p_o    = en[1] ? -$signed(p_pos) : $signed(p_pos);
    i_o    = en[1] ? -$signed(i_pos) : $signed(i_pos);
  end

  assign valid_o = |en;
  assign late_o  = en[0];

endmodule

// File: rtl/el_phase_det_chk.sv
module el_phase_det_chk #(
  parameter int HALF_TICKS = 1000,
  parameter int I_SHIFT    = 2,
  parameter int P_W        = 11
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic signed [P_W-1:0] p_o,
  input logic signed [P_W-1:0] i_o,
  input logic                  valid_o,
  input logic                  late_o
);

  assert_idle_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (p_o == 0 && i_o == 0 && !late_o));

  assert_late_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && late_o) |-> (p_o >= 0));

  assert_early_sign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !late_o) |-> (p_o <= 0));

  assert_saturate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(p_o) <= HALF_TICKS) && (int'(p_o) >= -HALF_TICKS));

  assert_iscale_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (late_o ? (int'(i_o) == (int'(p_o) >>> I_SHIFT))
                        : (-int'(i_o) == ((-int'(p_o)) >>> I_SHIFT))));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && $stable(late_o)) |-> $stable(p_o));

endmodule

bind el_phase_det el_phase_det_chk #(
  .HALF_TICKS (HALF_TICKS),
  .I_SHIFT    (I_SHIFT),
  .P_W        (P_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .p_o     (p_o),
  .i_o     (i_o),
  .valid_o (valid_o),
  .late_o  (late_o)
);

// File: tb/el_phase_det_test.sv
module el_phase_det_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 40;
  localparam int SHIFT      = 2;
  localparam int PW         = el_pd_pkg::cnt_w(HALF) + 1;
  localparam int LAT        = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lclk = 1'b0, lclk2x = 1'b0, pulse = 1'b0;
  logic signed [PW-1:0] p_w, i_w;
  logic valid, late;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  el_phase_det #(.HALF_TICKS(HALF), .I_SHIFT(SHIFT), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lclk_i(lclk), .lclk2x_i(lclk2x),
    .pulse_i(pulse), .p_o(p_w), .i_o(i_w), .valid_o(valid), .late_o(late)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: timestamps of sampled edges
  typedef struct { bit v; bit l; int p; int i; } exp_t;
  exp_t q[$];
  int  t = 0, late_t = -1, early_t = -1, fall_t = -1;
  int  m_dir = 0, m_mag = 0;
  bit  pc = 0, px = 0, pp = 0;

  always @(posedge clk) begin
    bit c, x, pu;
    exp_t e;
    if (rst_n) begin
      c = lclk; x = lclk2x; pu = pulse;
      if (!x && px) begin
        if (!c && pc && late_t >= 0) begin
          m_dir = 1; m_mag = (t - late_t > HALF) ? HALF : t - late_t;
        end else if (c && !pc && early_t >= 0) begin
          m_dir = 2; m_mag = (early_t - fall_t > HALF) ? HALF : early_t - fall_t;
        end else m_dir = 0;
        late_t = -1; early_t = -1;
      end
      if (!c && pc) fall_t = t;
      if (pu && !pp) begin
        if (c) begin if (late_t < 0) late_t = t; end
        else   begin if (early_t < 0) early_t = t; end
      end
      e.v = (m_dir != 0);
      e.l = (m_dir == 1);
      e.p = (m_dir == 1) ? m_mag : (m_dir == 2) ? -m_mag : 0;
      e.i = (m_dir == 1) ? (m_mag >> SHIFT) : (m_dir == 2) ? -(m_mag >> SHIFT) : 0;
      q.push_back(e);
      if (q.size() > LAT) void'(q.pop_front());
      pc = c; px = x; pp = pu; t++;
    end
  end

  // per-cycle comparison and window capture
  bit seen = 0, prev_v = 0;
  int cap_p = 999, cap_i = 999, cap_l = 9, run_len = 0, last_run = 0;

  always @(negedge clk) begin
    if (rst_n && q.size() == LAT) begin
      chk("R6 valid window", int'(valid), int'(q[0].v));
      chk("R2 late flag", int'(late), int'(q[0].l));
      chk("R3 P word", int'(p_w), q[0].p);
      chk("R8 I word", int'(i_w), q[0].i);
    end
    if (valid) begin
      seen = 1;
      if (!prev_v) begin
        cap_p = int'(p_w); cap_i = int'(i_w); cap_l = int'(late); run_len = 1;
      end else run_len++;
    end else if (prev_v) last_run = run_len;
    prev_v = valid;
  end

  task automatic run_period(input int h, input int l, input int pa, input int pb);
    for (int k = 0; k < h + l; k++) begin
      @(negedge clk);
      lclk   = (k < h);
      lclk2x = (k < h) ? (k >= h/2) : ((k - h) >= l/2);
      pulse  = (k >= pa && k < pa + 3) || (k >= pb && k < pb + 3);
    end
  endtask

  task automatic scen(input string tag, input int h, input int l, input int pa, input int pb,
                      input int e_l, input int e_p, input int e_i, input int e_run);
    cap_p = 999; cap_i = 999; cap_l = 9; last_run = 0;
    run_period(h, l, pa, pb);
    run_period(40, 40, -100, -100);
    chk({tag, " late_o"}, cap_l, e_l);
    chk({tag, " P"}, cap_p, e_p);
    chk({tag, " R8 I"}, cap_i, e_i);
    chk({tag, " R6 window length"}, last_run, e_run);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(valid), 0);
    chk("R1 P in reset", int'(p_w), 0);
    chk("R1 I in reset", int'(i_w), 0);
    chk("R1 late in reset", int'(late), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 valid after reset", int'(valid), 0);
    chk("R9 P idle after reset", int'(p_w), 0);

    run_period(40, 40, -100, -100);
    run_period(40, 40, -100, -100);
    chk("R5 no pulse no valid", int'(seen), 0);

    scen("R3 late 10",        40, 40, 30,  -100, 1,  10,  2, 40);
    scen("R4 early 7",        40, 40, 47,  -100, 0,  -7, -1, 40);
    scen("R3 late 39",        40, 40, 1,   -100, 1,  39,  9, 40);
    scen("R4 early 33",       40, 40, 73,  -100, 0, -33, -8, 40);
    scen("R7 late clipped",   60, 40, 2,   -100, 1,  40, 10, 40);
    scen("R7 early clipped",  40, 60, 95,  -100, 0, -40, -10, 40);
    scen("R10 two late",      40, 40, 10,  25,   1,  30,  7, 40);
    scen("R10 two early",     40, 40, 45,  60,   0,  -5, -1, 40);
    scen("R6 short low",      40, 20, 30,  -100, 1,  10,  2, 20);

    run_period(40, 40, -100, -100);
    seen = 0;
    run_period(40, 40, -100, -100);
    chk("R5 full low phase without pulse", int'(seen), 0);
    chk("R9 P idle", int'(p_w), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule